// File: doc/BRIEF.md
# Guarded Overflow Timer (Watchdog / Interval)

An 8-bit up-counter advances on enable pulses from a free-running system-clock divider. A three-bit select field chooses one of eight divider taps. A mode bit decides what a wrap of the counter from its top value back to zero does. In watchdog mode the wrap raises a fixed-length overflow pulse, which system logic can turn into a reset. In interval mode the wrap holds an interrupt line high until software acknowledges it. Both modes set a sticky flag in the control/status byte.

Software writes through a 16-bit bus word. The upper byte is a key and the lower byte is the payload, so that a stray write cannot change the counter or the control byte. The key alone picks the target register. The read select input picks which byte appears on the read bus. A hardware standby input clears every register, the same way reset does.

Clearing the flag takes two steps. Software first reads the control byte while the flag is set, then writes zero to the flag. Software that reloads the counter fast enough keeps the watchdog from firing.

Top module: `wdt_interval_timer`

## Requirements
- R1: While the run bit (control bit 5) is 1, the counter goes up by exactly one on each enable pulse from the selected tap, and stays unchanged between pulses.
- R2: When the counter wraps from 0xFF to 0x00, the flag (control bit 7) becomes 1.
- R3: The counter reads 0x00 on every cycle after a cycle in which the run bit is 0, whatever write arrives.
- R4: Reading with the read select at 0 returns {flag, mode, run, 1, 1, sel[2:0]}. After reset this byte is 0x18 and the counter is 0x00. Reading with the read select at 1 returns the counter.
- R5: A control write with payload bit 7 at 0 clears the flag only if a control read saw the flag at 1 after the last control write. Without such a read the flag stays set. A payload bit 7 of 1 never sets the flag.
- R6: A write with key 0x5A loads the payload into the counter. A write with key 0xA5 loads mode (bit 6), run (bit 5) and select (bits 2:0) from the payload. A write with any other key changes nothing.
- R7: Select values 0 to 7 give one enable pulse every 2, 64, 128, 512, 2048, 8192, 32768 and 131072 clocks.
- R8: In watchdog mode (mode bit 1), a wrap drives the watchdog output high for exactly 8 consecutive clocks, and the interrupt output stays low.
- R9: In interval mode (mode bit 0), the interrupt output is high exactly while the flag is set, and the watchdog output stays low.
- R10: A counter load in the same cycle as an enable pulse wins over the increment. A wrap in the same cycle as a flag-clear write leaves the flag set.
- R11: A hardware standby cycle returns the control byte to 0x18 and the counter to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_stby | input | 1 | Hardware standby; synchronous clear of all state |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Keyed write strobe |
| bus_sel | input | 1 | Read select: 0 control/status byte, 1 counter |
| bus_wdata | input | 16 | Write word: key in [15:8], payload in [7:0] |
| bus_rdata | output | 8 | Read data for the selected byte |
| wdog_ovf | output | 1 | Watchdog overflow pulse |
| ivl_irq | output | 1 | Interval interrupt level |

## Verification
The bench checks the two-step flag clear in both directions. A design that skips the read step would clear the flag on a write alone, and one that honours a payload bit 7 of 1 would set the flag with no wrap. It checks that counter loads read back exactly in both phases of the fastest tap; a design that lets the increment win would read one count high. It checks writes with wrong keys for both registers, which a loosely decoded design would accept. It measures the watchdog pulse to the cycle and checks that the run bit and standby hold the counter at zero; a design that only paused the counter would keep its old value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   localparam int unsigned SEL_W    = 3;
   localparam int unsigned NUM_TAPS = 1 << SEL_W;

   // log2 of the divider ratio for each select code
   function automatic int unsigned tap_log2(input int unsigned idx);
      case (idx)
         0:       return 1;
         1:       return 6;
         2:       return 7;
         3:       return 9;
         4:       return 11;
         5:       return 13;
         6:       return 15;
         default: return 17;
      endcase
   endfunction

   typedef struct packed {
      logic             flag;
      logic             wdog_mode;
      logic             run;
      logic [SEL_W-1:0] sel;
   } ctl_t;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
   import wdt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int unsigned DIV_W = tap_log2(NUM_TAPS - 1);

   logic [DIV_W-1:0]    div_q;
   logic [NUM_TAPS-1:0] tap_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   div_q <= '0;
      else if (clr) div_q <= '0;
      else          div_q <= div_q + 1'b1;
   end

   for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
      localparam int unsigned E = tap_log2(g);
      if (E < 1 || E > DIV_W) begin : g_bad
         $error("tap exponent out of divider range");
      end
      if (g > 0) begin : g_order
         if (tap_log2(g) <= tap_log2(g - 1)) begin : g_bad_order
            $error("tap ratios must rise with the select code");
         end
      end
      assign tap_vec[g] = &div_q[E-1:0];
   end

   assign tick = tap_vec[sel];

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic             tick,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);
   logic [CNT_W-1:0] cnt_q;

   assign ovf = run & tick & ~ld & (&cnt_q);
   assign cnt = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (clr || !run)   cnt_q <= '0;
      else if (ld)            cnt_q <= ld_val;
      else if (tick)          cnt_q <= cnt_q + 1'b1;
   end

   assert_cnt_held_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0));

   assert_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ld && !clr) |=> (cnt_q == $past(cnt_q) + CNT_W'($past(tick))));

   assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (run && ld && !clr) |=> (cnt_q == $past(ld_val)));

endmodule

// File: rtl/wdt_ctl.sv
module wdt_ctl
   import wdt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       rd_ctl,
   input  logic       wr_ctl,
   input  logic [7:0] payload,
   input  logic       ovf,
   output ctl_t       ctl
);
   ctl_t ctl_q;
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   armed_q <= 1'b0;
      else if (clr || wr_ctl)       armed_q <= 1'b0;
      else if (rd_ctl && ctl_q.flag) armed_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (clr) begin
         ctl_q <= '0;
      end else begin
         if (ovf)                               ctl_q.flag <= 1'b1;
         else if (wr_ctl && !payload[7] && armed_q) ctl_q.flag <= 1'b0;
         if (wr_ctl) begin
            ctl_q.wdog_mode <= payload[6];
            ctl_q.run       <= payload[5];
            ctl_q.sel       <= payload[SEL_W-1:0];
         end
      end
   end

   assign ctl = ctl_q;

   assert_wrap_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr) |=> ctl_q.flag);

   assert_flag_no_self_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q.flag && !ovf) |=> !ctl_q.flag);

   assert_flag_needs_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.flag && !armed_q && !clr) |=> ctl_q.flag);

endmodule

// File: rtl/wdt_outputs.sv
module wdt_outputs #(
   parameter int unsigned PULSE_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic ovf,
   input  logic wdog_mode,
   input  logic flag,
   output logic wdog_ovf,
   output logic ivl_irq
);
   localparam int unsigned PCNT_W = $clog2(PULSE_LEN + 1);

   if (PULSE_LEN < 1) begin : g_bad_len
      $error("pulse length must be at least one clock");
   end

   logic [PCNT_W-1:0] pcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pcnt_q <= '0;
      else if (clr)                pcnt_q <= '0;
      else if (ovf && wdog_mode)   pcnt_q <= PCNT_W'(PULSE_LEN);
      else if (pcnt_q != '0)       pcnt_q <= pcnt_q - 1'b1;
   end

   assign wdog_ovf = (pcnt_q != '0);
   assign ivl_irq  = flag & ~wdog_mode;

   assert_pulse_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && wdog_mode && !clr) |=> wdog_ovf);

endmodule

// File: rtl/wdt_interval_timer.sv
module wdt_interval_timer
   import wdt_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned PULSE_LEN = 8,
   parameter logic [7:0]  KEY_CNT   = 8'h5A,
   parameter logic [7:0]  KEY_CTL   = 8'hA5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hw_stby,
   input  logic        bus_rd,
   input  logic        bus_wr,
   input  logic        bus_sel,
   input  logic [15:0] bus_wdata,
   output logic [7:0]  bus_rdata,
   output logic        wdog_ovf,
   output logic        ivl_irq
);
   localparam int unsigned BYTE_W = 8;

   if (CNT_W < 2 || CNT_W > BYTE_W) begin : g_bad_width
      $error("counter width must fit the data byte");
   end
   if (KEY_CNT == KEY_CTL) begin : g_bad_keys
      $error("the two write keys must differ");
   end

   logic [BYTE_W-1:0] key, payload;
   logic              ld_cnt, wr_ctl, rd_ctl, tick, ovf;
   logic [CNT_W-1:0]  cnt;
   ctl_t              ctl;

   assign key     = bus_wdata[2*BYTE_W-1:BYTE_W];
   assign payload = bus_wdata[BYTE_W-1:0];
   assign ld_cnt  = bus_wr && (key == KEY_CNT);
   assign wr_ctl  = bus_wr && (key == KEY_CTL);
   assign rd_ctl  = bus_rd && !bus_sel;

   wdt_prescaler u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (hw_stby),
      .sel   (ctl.sel),
      .tick  (tick)
   );

   wdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (hw_stby),
      .run    (ctl.run),
      .tick   (tick),
      .ld     (ld_cnt),
      .ld_val (payload[CNT_W-1:0]),
      .cnt    (cnt),
      .ovf    (ovf)
   );

   wdt_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (hw_stby),
      .rd_ctl  (rd_ctl),
      .wr_ctl  (wr_ctl),
      .payload (payload),
      .ovf     (ovf),
      .ctl     (ctl)
   );

   wdt_outputs #(.PULSE_LEN(PULSE_LEN)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (hw_stby),
      .ovf       (ovf),
      .wdog_mode (ctl.wdog_mode),
      .flag      (ctl.flag),
      .wdog_ovf  (wdog_ovf),
      .ivl_irq   (ivl_irq)
   );

   assign bus_rdata = bus_sel ? BYTE_W'(cnt)
                              : {ctl.flag, ctl.wdog_mode, ctl.run, 2'b11, ctl.sel};

   assert_bad_key_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && key != KEY_CTL && !hw_stby)
         |=> $stable({ctl.wdog_mode, ctl.run, ctl.sel}));

   assert_standby_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      hw_stby |=> (bus_rdata == 8'h18 || bus_sel) && !wdog_ovf && !ivl_irq);

endmodule

// File: tb/test_wdt_interval_timer.sv
`timescale 1ns/100ps
module test_wdt_interval_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hw_stby = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_sel = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        wdog_ovf, ivl_irq;

   int unsigned n_run = 0, n_fail = 0;
   bit          done = 0;

   always #2.5 clk = ~clk;

   wdt_interval_timer i_wdt_interval_timer (
      .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .wdog_ovf(wdog_ovf), .ivl_irq(ivl_irq)
   );

   // scoreboard queues
   logic [7:0] exp_q[$];
   string      tag_q[$];
   event       rd_ev;

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
      end
   endtask

   // monitor: compares read data shortly after the read is driven
   initial forever begin
      @(rd_ev);
      #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
   end

   // driver tasks
   task automatic expect_read(input logic sel, input logic [7:0] exp, input string tag);
      @(negedge clk);
      bus_rd = 1'b1; bus_sel = sel;
      exp_q.push_back(exp); tag_q.push_back(tag);
      ->rd_ev;
      @(posedge clk); #1 bus_rd = 1'b0;
   endtask

   task automatic raw_read(input logic sel, output logic [7:0] val);
      @(negedge clk);
      bus_rd = 1'b1; bus_sel = sel;
      #1 val = bus_rdata;
      @(posedge clk); #1 bus_rd = 1'b0;
   endtask

   task automatic bus_write(input logic [7:0] key, input logic [7:0] data);
      @(negedge clk);
      bus_wr = 1'b1; bus_wdata = {key, data};
      @(posedge clk); #1 bus_wr = 1'b0;
   endtask

   task automatic rate_check(input logic [2:0] sel, input int unsigned ratio, input string tag);
      logic [7:0] v;
      bus_write(8'hA5, {5'b0010_0, sel});
      bus_write(8'h5A, 8'h00);
      raw_read(1'b1, v);
      repeat (10 * ratio - 1) @(negedge clk);
      expect_read(1'b1, v + 8'd10, tag);
   endtask

   // watchdog
   initial begin
      for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int hi, wait_c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R4 reset state
      expect_read(1'b0, 8'h18, "R4 control after reset");
      expect_read(1'b1, 8'h00, "R4 counter after reset");
      @(negedge clk);
      check("R8 pulse low after reset", {7'b0, wdog_ovf}, 8'h00);
      check("R9 irq low after reset", {7'b0, ivl_irq}, 8'h00);

      // R1 / R7 rates for three taps
      rate_check(3'd0, 2,   "R1 R7 tap 2");
      rate_check(3'd1, 64,  "R7 tap 64");
      rate_check(3'd2, 128, "R7 tap 128");

      // R3 clearing run zeroes counter, even with a load
      bus_write(8'hA5, 8'h02);
      bus_write(8'h5A, 8'h33);
      expect_read(1'b1, 8'h00, "R3 counter held at zero");

      // R6 keyed access, slow tap so no tick in the window
      bus_write(8'hA5, 8'h27);
      bus_write(8'h5A, 8'h40);
      expect_read(1'b1, 8'h40, "R6 counter load key");
      bus_write(8'h5B, 8'h99);
      expect_read(1'b1, 8'h40, "R6 wrong counter key ignored");
      bus_write(8'h00, 8'h42);
      expect_read(1'b0, 8'h3F, "R6 wrong control key ignored");

      // R11 standby
      @(negedge clk); hw_stby = 1'b1;
      @(negedge clk); hw_stby = 1'b0;
      expect_read(1'b0, 8'h18, "R11 control after standby");
      expect_read(1'b1, 8'h00, "R11 counter after standby");

      // R10 load beats increment, both tick phases
      bus_write(8'hA5, 8'h20);
      bus_write(8'h5A, 8'h20);
      expect_read(1'b1, 8'h20, "R10 load phase A");
      @(negedge clk);
      bus_write(8'h5A, 8'h21);
      expect_read(1'b1, 8'h21, "R10 load phase B");

      // R8 watchdog pulse
      bus_write(8'hA5, 8'h60);
      bus_write(8'h5A, 8'hFF);
      wait_c = 0;
      @(negedge clk);
      while (!wdog_ovf && wait_c < 10) begin @(negedge clk); wait_c++; end
      hi = 0;
      while (wdog_ovf && hi < 20) begin
         if (ivl_irq) check("R8 irq stays low", 8'h01, 8'h00);
         hi++; @(negedge clk);
      end
      check("R8 pulse width", 8'(hi), 8'd8);

      // R5 flag clear sequence; stop the timer first (write carries bit7=0, no read)
      bus_write(8'hA5, 8'h40);
      expect_read(1'b0, 8'hD8, "R2 R5 flag kept without prior read");
      bus_write(8'hA5, 8'h40);
      expect_read(1'b0, 8'h58, "R5 flag cleared after read");
      bus_write(8'hA5, 8'hC0);
      expect_read(1'b0, 8'h58, "R5 writing one does not set flag");

      // R9 interval mode
      bus_write(8'hA5, 8'h20);
      bus_write(8'h5A, 8'hFF);
      repeat (4) @(negedge clk);
      check("R9 irq high after wrap", {7'b0, ivl_irq}, 8'h01);
      check("R9 watchdog output low", {7'b0, wdog_ovf}, 8'h00);
      expect_read(1'b0, 8'hB8, "R2 flag set in interval mode");
      bus_write(8'hA5, 8'h00);
      @(negedge clk);
      check("R9 irq drops with flag", {7'b0, ivl_irq}, 8'h00);

      repeat (2) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule